// File: doc/BRIEF.md
# Indexed Port Bridge with Lock Windows

This block lets a narrow four-byte I/O port window reach a byte-wide memory with a 16-bit address space, such as a battery-backed store with a register file behind it. Software first loads a 16-bit index, one byte at a time, through two address ports. It then moves one byte through a data port. After every data write the index returns to zero, so each new access has to load its own address.

Two lock bits can close two fixed 16-byte windows. While a window's lock bit is set, locations in that window read as all-ones and cannot be written. Indices at or beyond the configured memory size behave the same way. On the memory side the bridge drives registered single-cycle strobes. The memory answers a read in the cycle its read strobe is high, and that is also the cycle in which the port read result is presented.

Top module: `idx_port_bridge`

## Requirements
- R1: A port write at offset 0 replaces bits [7:0] of the index, and a write at offset 1 replaces bits [15:8]. Each leaves the other byte as it was.
- R2: A port write at offset 3 to a permitted index raises `mem_we` for exactly one cycle, in the cycle after the port write, with `mem_addr` equal to the index and `mem_wdata` equal to the port data. Every offset-3 write, permitted or not, sets the index to 0x0000.
- R3: A port read at offset 3 of a permitted index raises `mem_re` and `port_rvalid` together in the next cycle, with `mem_addr` equal to the index and `port_rdata` equal to `mem_rdata`. The read leaves the index unchanged.
- R4: A port read at offset 0, 1 or 2 gives `port_rvalid` in the next cycle with `port_rdata` = 0xFF, and it raises no `mem_re`.
- R5: A port write at offset 2 changes neither the index nor the memory.
- R6: With lock bit 0 set, indices 0x0020 to 0x002F are blocked. With lock bit 1 set, indices 0x0030 to 0x003F are blocked. A blocked read returns 0xFF with no `mem_re`, and a blocked write raises no `mem_we`.
- R7: A `lock_toggle` pulse inverts the lock bit selected by `lock_sel`. Reset clears both lock bits and the index.
- R8: An index at or above `MEM_SIZE` raises no strobe. A read of such an index returns 0xFF.
- R9: A port read in the same cycle as a port write is dropped: it produces no `port_rvalid` and no `mem_re`. The write is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_wr | input | 1 | Port write request, one cycle |
| port_rd | input | 1 | Port read request, one cycle |
| port_off | input | 2 | Port offset: 0 index low, 1 index high, 2 unused, 3 data |
| port_wdata | input | 8 | Port write data |
| port_rdata | output | 8 | Port read data, valid while `port_rvalid` is high |
| port_rvalid | output | 1 | Read result valid, one cycle after `port_rd` |
| lock_toggle | input | 1 | Inverts the selected lock bit |
| lock_sel | input | 1 | Selects which lock bit to invert |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe, one cycle |
| mem_rdata | input | 8 | Memory read data, valid while `mem_re` is high |

## Verification
The bench sweeps every index from 0x00 to 0x7F with a small memory size. This catches an off-by-one at the size limit, which would show up as a stray write strobe or as real data where 0xFF is expected. It opens and closes each lock window around its edges, including both windows locked at once. A wrong window base or a wrong lock polarity shows as data leaking from a closed window, or as 0xFF returned from an open one.

The bench issues back-to-back data writes without reloading the index. A bridge that fails to clear the index after a blocked write would send the second write to the wrong location. The bench also reloads one index byte and checks that the other byte survives. It checks that offset-2 writes are dropped and that a read arriving together with a write is dropped. It checks that reset reopens both windows.

// File: rtl/idxb_pkg.sv
// Package: shared widths and port offset encoding for the indexed port bridge.
// Assumes byte-wide data and a 16-bit index.
package idxb_pkg;
    localparam int IDX_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OFF_IDX_LO = 2'd0,
        OFF_IDX_HI = 2'd1,
        OFF_SPARE  = 2'd2,
        OFF_DATA   = 2'd3
    } port_off_e;
endpackage

// File: rtl/idxb_index_reg.sv
// Module: holds the 16-bit index that the port accesses use.
// Offset 0 and offset 1 writes load one byte each. Every data write clears
// the index. Assumes that at most one port write arrives per cycle.
module idxb_index_reg
    import idxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_off,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  idx
);
    // Updates one index byte, or clears the whole index after a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (wr_en) begin
            case (wr_off)
                OFF_IDX_LO: idx[BYTE_W-1:0]     <= wr_data;
                OFF_IDX_HI: idx[IDX_W-1:BYTE_W] <= wr_data;
                OFF_DATA:   idx                 <= '0;
                default:    idx                 <= idx;
            endcase
        end
    end

    // R2
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_DATA) |=> (idx == '0));

    // R1
    idx_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_IDX_LO) |=> (idx[IDX_W-1:BYTE_W] == $past(idx[IDX_W-1:BYTE_W])));

    // R5
    idx_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_SPARE) |=> $stable(idx));
endmodule

// File: rtl/idxb_lock_ctl.sv
// Module: holds the lock bits and decides whether an index falls in a
// closed window. Window i covers WIN_BASE + i*WIN_SPAN for WIN_SPAN bytes.
// Assumes lock_sel is below N_LOCK whenever lock_toggle is high.
module idxb_lock_ctl
    import idxb_pkg::*;
#(
    parameter int N_LOCK   = 2,
    parameter int WIN_BASE = 32,
    parameter int WIN_SPAN = 16,
    localparam int SEL_W   = (N_LOCK > 1) ? $clog2(N_LOCK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_toggle,
    input  logic [SEL_W-1:0] lock_sel,
    input  logic [IDX_W-1:0] idx,
    output logic [N_LOCK-1:0] lock_q,
    output logic             blocked
);
    logic [N_LOCK-1:0] hit;

    // Inverts the selected lock bit on each toggle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (lock_toggle) begin
            lock_q <= lock_q ^ (N_LOCK'(1) << lock_sel);
        end
    end

    // Decodes the window of each lock bit.
    for (genvar gi = 0; gi < N_LOCK; gi++) begin : g_win
        localparam int LO = WIN_BASE + gi * WIN_SPAN;
        localparam int HI = LO + WIN_SPAN;
        always_comb begin
            hit[gi] = lock_q[gi] && (32'(idx) >= LO) && (32'(idx) < HI);
        end
    end

    // Combines the per-window hits into one block flag.
    always_comb begin
        blocked = |hit;
    end

    // R7
    lock_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_toggle |=> ((lock_q ^ $past(lock_q)) == (N_LOCK'(1) << $past(lock_sel))));
endmodule

// File: rtl/idxb_strobe_gen.sv
// Module: registers the memory-side strobes, the address, the write data and
// the read-valid flag. Each strobe lasts one cycle per accepted request.
// Assumes the caller has already applied the lock and range checks.
module idxb_strobe_gen
    import idxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic              rd_any,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [IDX_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic              rvalid
);
    // Raises the single-cycle strobes and the read-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we <= 1'b0;
            mem_re <= 1'b0;
            rvalid <= 1'b0;
        end else begin
            mem_we <= wr_go;
            mem_re <= rd_go;
            rvalid <= rd_any;
        end
    end

    // Captures the address and data that belong to an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            if (wr_go || rd_go) mem_addr  <= idx;
            if (wr_go)          mem_wdata <= wdata;
        end
    end

    // R9
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R3
    re_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> rvalid);
endmodule

// File: rtl/idx_port_bridge.sv
// Module: top of the indexed port bridge. Four port offsets (index low,
// index high, unused, data) reach a byte memory through a 16-bit index.
// Lock windows and the size limit gate the memory strobes. Assumes the
// memory returns mem_rdata in the same cycle that mem_re is high.
module idx_port_bridge
    import idxb_pkg::*;
#(
    parameter int MEM_SIZE = 8192,
    parameter int N_LOCK   = 2,
    parameter int WIN_BASE = 32,
    parameter int WIN_SPAN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_wr,
    input  logic        port_rd,
    input  logic [1:0]  port_off,
    input  logic [7:0]  port_wdata,
    output logic [7:0]  port_rdata,
    output logic        port_rvalid,
    input  logic        lock_toggle,
    input  logic        lock_sel,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata
);
    localparam logic [BYTE_W-1:0] ALL_ONES = '1;

    logic [IDX_W-1:0]  idx;
    logic [N_LOCK-1:0] lock_q;
    logic              blocked;
    logic              in_range;
    logic              permit;
    logic              wr_go;
    logic              rd_any;
    logic              rd_go;

    idxb_index_reg u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (port_wr),
        .wr_off  (port_off),
        .wr_data (port_wdata),
        .idx     (idx)
    );

    idxb_lock_ctl #(
        .N_LOCK   (N_LOCK),
        .WIN_BASE (WIN_BASE),
        .WIN_SPAN (WIN_SPAN)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_toggle (lock_toggle),
        .lock_sel    (lock_sel),
        .idx         (idx),
        .lock_q      (lock_q),
        .blocked     (blocked)
    );

    // Decides whether the current index may reach the memory.
    always_comb begin
        in_range = (32'(idx) < MEM_SIZE);
        permit   = in_range && !blocked;
        wr_go    = port_wr && (port_off == OFF_DATA) && permit;
        rd_any   = port_rd && !port_wr;
        rd_go    = rd_any && (port_off == OFF_DATA) && permit;
    end

    idxb_strobe_gen u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .rd_any    (rd_any),
        .idx       (idx),
        .wdata     (port_wdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .rvalid    (port_rvalid)
    );

    // Returns memory data for a granted read and all-ones otherwise.
    always_comb begin
        port_rdata = mem_re ? mem_rdata : ALL_ONES;
    end

    // R6
    lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(blocked));

    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (32'(mem_addr) < MEM_SIZE));

    // R4
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rvalid |-> $past(port_rd && !port_wr));
endmodule

// File: tb/idx_port_bridge_tb.sv
`timescale 1ns/1ps
module idx_port_bridge_tb;
    localparam int MSZ = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_wr = 1'b0;
    logic        port_rd = 1'b0;
    logic [1:0]  port_off = 2'd0;
    logic [7:0]  port_wdata = 8'd0;
    logic [7:0]  port_rdata;
    logic        port_rvalid;
    logic        lock_toggle = 1'b0;
    logic        lock_sel = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata;

    logic [7:0] bmem [0:255];
    logic [7:0] exp_mem [0:255];
    logic [1:0] lk;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    idx_port_bridge #(.MEM_SIZE(MSZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
        .port_off(port_off), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .port_rvalid(port_rvalid), .lock_toggle(lock_toggle), .lock_sel(lock_sel),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem_re ? bmem[mem_addr[7:0]] : 8'h00;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit open_idx(input int a);
        if (a >= MSZ) return 1'b0;
        if (lk[0] && a >= 32'h20 && a < 32'h30) return 1'b0;
        if (lk[1] && a >= 32'h30 && a < 32'h40) return 1'b0;
        return 1'b1;
    endfunction

    task automatic pwrite(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        port_wr = 1'b1; port_off = off; port_wdata = d;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic set_idx(input int a);
        pwrite(2'd0, a[7:0]);
        pwrite(2'd1, a[15:8]);
    endtask

    // data write at idx a (already loaded), checks strobe after one cycle
    task automatic dwrite(input string tag, input int a, input logic [7:0] d);
        bit ok;
        ok = open_idx(a);
        pwrite(2'd3, d);
        chk({tag, " mem_we"}, int'(mem_we), int'(ok));
        if (ok) begin
            chk({tag, " mem_addr"}, int'(mem_addr), a);
            chk({tag, " mem_wdata"}, int'(mem_wdata), int'(d));
            exp_mem[a] = d;
        end
    endtask

    task automatic pread(input string tag, input logic [1:0] off, input int exp_d, input bit exp_re);
        @(negedge clk);
        port_rd = 1'b1; port_off = off;
        @(negedge clk);
        port_rd = 1'b0;
        chk({tag, " rvalid"}, int'(port_rvalid), 1);
        chk({tag, " mem_re"}, int'(mem_re), int'(exp_re));
        chk({tag, " rdata"}, int'(port_rdata), exp_d);
    endtask

    task automatic rd_idx(input string tag, input int a);
        bit ok;
        ok = open_idx(a);
        pread(tag, 2'd3, ok ? int'(exp_mem[a]) : 32'hFF, ok);
    endtask

    task automatic toggle(input logic s);
        @(negedge clk);
        lock_toggle = 1'b1; lock_sel = s;
        @(negedge clk);
        lock_toggle = 1'b0;
        lk[s] = ~lk[s];
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        lk = 2'b00;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 reset mem_we", int'(mem_we), 0);
        chk("R7 reset mem_re", int'(mem_re), 0);
        chk("R7 reset rvalid", int'(port_rvalid), 0);

        // R2 R8 write sweep across the size limit
        for (int a = 0; a < 128; a++) begin
            set_idx(a);
            dwrite("R2/R8 sweep write", a, 8'(a ^ 8'h5A));
        end
        // R3 R8 read sweep
        for (int a = 0; a < 128; a++) begin
            set_idx(a);
            rd_idx("R3/R8 sweep read", a);
        end

        // R4 other offsets read all-ones
        for (int o = 0; o < 3; o++) pread("R4 other offset", 2'(o), 32'hFF, 1'b0);

        // R6 window 0
        toggle(1'b0);
        for (int a = 32'h1E; a < 32'h42; a++) begin
            set_idx(a);
            rd_idx("R6 lock0 read", a);
        end
        set_idx(32'h25);
        dwrite("R6 lock0 write dropped", 32'h25, 8'hC3);
        toggle(1'b1);
        set_idx(32'h25); rd_idx("R6 both locked 25", 32'h25);
        set_idx(32'h35); rd_idx("R6 both locked 35", 32'h35);
        set_idx(32'h2F); rd_idx("R6 both locked 2F", 32'h2F);
        set_idx(32'h40); rd_idx("R6 both locked 40", 32'h40);
        toggle(1'b0);
        set_idx(32'h25); rd_idx("R7 lock0 reopened", 32'h25);
        set_idx(32'h35); rd_idx("R6 lock1 only", 32'h35);
        set_idx(32'h35);
        dwrite("R6 lock1 write dropped", 32'h35, 8'h11);
        toggle(1'b1);
        set_idx(32'h35);
        dwrite("R6 lock1 reopened write", 32'h35, 8'h77);
        set_idx(32'h35); rd_idx("R6 lock1 reopened read", 32'h35);

        // R2 index clears after data write
        set_idx(32'h42);
        dwrite("R2 first write", 32'h42, 8'h11);
        dwrite("R2 auto-clear", 0, 8'h99);
        toggle(1'b0);
        set_idx(32'h2A);
        dwrite("R2 blocked write", 32'h2A, 8'h44);
        dwrite("R2 clear after blocked", 0, 8'h66);
        toggle(1'b0);
        set_idx(0); rd_idx("R2 readback 0", 0);

        // R1 byte independence
        set_idx(32'h11);
        pwrite(2'd1, 8'h01);
        rd_idx("R1 high set", 32'h111);
        pwrite(2'd1, 8'h00);
        rd_idx("R1 low kept", 32'h11);
        pwrite(2'd0, 8'h13);
        rd_idx("R1 low replaced", 32'h13);
        pwrite(2'd1, 8'h01);
        pwrite(2'd0, 8'h05);
        rd_idx("R1 high kept", 32'h105);
        pwrite(2'd1, 8'h00);
        rd_idx("R1 back in range", 32'h05);

        // R3 read keeps index
        set_idx(32'h17);
        rd_idx("R3 poll 1", 32'h17);
        rd_idx("R3 poll 2", 32'h17);

        // R5 offset 2 write ignored
        set_idx(32'h12);
        pwrite(2'd2, 8'h33);
        chk("R5 no mem_we", int'(mem_we), 0);
        rd_idx("R5 index kept", 32'h12);

        // R9 read with write dropped
        set_idx(32'h14);
        @(negedge clk);
        port_wr = 1'b1; port_rd = 1'b1; port_off = 2'd3; port_wdata = 8'hAB;
        @(negedge clk);
        port_wr = 1'b0; port_rd = 1'b0;
        chk("R9 rvalid dropped", int'(port_rvalid), 0);
        chk("R9 mem_re dropped", int'(mem_re), 0);
        chk("R9 write done", int'(mem_we), 1);
        chk("R9 write addr", int'(mem_addr), 32'h14);
        exp_mem[32'h14] = 8'hAB;
        set_idx(32'h14); rd_idx("R9 readback", 32'h14);

        // R7 reset clears locks and index
        toggle(1'b0);
        toggle(1'b1);
        set_idx(32'h25);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        lk = 2'b00;
        rd_idx("R7 index cleared", 0);
        set_idx(32'h25); rd_idx("R7 lock0 cleared", 32'h25);
        set_idx(32'h35); rd_idx("R7 lock1 cleared", 32'h35);

        finish_up();
    end
endmodule